// File: doc/BRIEF.md
# Self-Starting Five-State Sequence Counter

A 3-bit synchronous counter that walks a fixed, non-binary cycle of five codes: 000, 010, 011, 101, 110, then back to 000. It advances on a rising clock edge while its count enable is high and otherwise keeps its value. The register contents are the only output. Downstream logic can decode each code directly.

The three codes outside the cycle (001, 100, 111) each have a defined successor. A counter that wakes up in any of them joins the cycle within two advancing edges, so it needs no reset to run correctly. An active-low asynchronous reset still clears it to 000. A synchronous parallel load places any of the eight codes into the register. This is how a system, or a bench, starts the counter from an arbitrary code.

Top module: `seq5_counter`

## Requirements
- R1: While `rst_n` is low, `state` reads 000, whatever the clock and other inputs are doing.
- R2: With `count_en`=1 and `load_en`=0, a rising edge moves the state along the cycle 000→010→011→101→110→000.
- R3: With `count_en`=1 and `load_en`=0, the unused codes step as 001→111, 111→101 and 100→011.
- R4: From any of the eight codes, at most two advancing edges bring the state to a code of the valid cycle. From 001 it takes exactly two, through 111 to 101.
- R5: With `count_en`=0 and `load_en`=0, the state does not change across a rising edge.
- R6: With `load_en`=1, the next rising edge puts `load_val` into the state, and `count_en` has no effect in that cycle.
- R7: Bit positions are fixed: `state[2]` is C, `state[1]` is B and `state[0]` is A. All codes in R2 to R4 are written CBA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset to 000 |
| count_en | input | 1 | Advance one step per edge when high |
| load_en | input | 1 | Synchronous load, takes priority over counting |
| load_val | input | 3 | Code to load, CBA order |
| state | output | 3 | Counter state, C in bit 2, A in bit 0 |

## Verification
The block has no parameters. The bench builds it in its only configuration, and all eight codes of the 3-bit space can be tested. The parallel load places every code, including the three unused ones, so each transition is compared one by one against a table kept in the bench. The bench counts two steps from 001 to reach the cycle. It also checks that load overrides counting, that the state holds while the counter is idle, and that reset clears the state in the middle of a run.

// File: rtl/seq5_counter.sv
module seq5_counter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       count_en,
  input  logic       load_en,
  input  logic [2:0] load_val,
  output logic [2:0] state
);

  logic c, b, a;
  logic [2:0] step;

  assign {c, b, a} = state;

  // C+ = A ; B+ = ~B | ~A~C ; A+ from the self-starting assignment
  assign step[2] = a;
  assign step[1] = ~b | (~a & ~c);
  assign step[0] = (~c & (a | b)) | (c & ~(a ^ b));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      state <= 3'b000;
    else if (load_en)
      state <= load_val;
    else if (count_en)
      state <= step;
  end

  logic adv;
  assign adv = count_en & ~load_en;

  function automatic logic in_cycle(input logic [2:0] s);
    return (s == 3'b000) || (s == 3'b010) || (s == 3'b011) ||
           (s == 3'b101) || (s == 3'b110);
  endfunction

  assert_cyc0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && state == 3'b000) |=> state == 3'b010);
  assert_cyc1_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && state == 3'b010) |=> state == 3'b011);
  assert_cyc2_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && state == 3'b011) |=> state == 3'b101);
  assert_cyc3_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && state == 3'b101) |=> state == 3'b110);
  assert_cyc4_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && state == 3'b110) |=> state == 3'b000);

  assert_unused001_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && state == 3'b001) |=> state == 3'b111);
  assert_unused111_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && state == 3'b111) |=> state == 3'b101);
  assert_unused100_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && state == 3'b100) |=> state == 3'b011);

  assert_recover_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !in_cycle(state)) ##1 adv |=> in_cycle(state));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_en && !load_en) |=> $stable(state));

  assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> state == $past(load_val));

endmodule

// File: tb/seq5_counter_tb.sv
module seq5_counter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       count_en = 1'b0;
  logic       load_en = 1'b0;
  logic [2:0] load_val = 3'b000;
  logic [2:0] state;

  int checks = 0;
  int errors = 0;
  logic [2:0] model = 3'b000;

  typedef struct { logic [2:0] exp; string tag; } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;

  seq5_counter u_dut (
    .clk(clk), .rst_n(rst_n), .count_en(count_en),
    .load_en(load_en), .load_val(load_val), .state(state)
  );

  function automatic logic [2:0] ref_next(input logic [2:0] s);
    case (s)
      3'b000: return 3'b010;
      3'b010: return 3'b011;
      3'b011: return 3'b101;
      3'b101: return 3'b110;
      3'b110: return 3'b000;
      3'b001: return 3'b111;
      3'b111: return 3'b101;
      default: return 3'b011;
    endcase
  endfunction

  function automatic bit valid(input logic [2:0] s);
    return s == 3'b000 || s == 3'b010 || s == 3'b011 || s == 3'b101 || s == 3'b110;
  endfunction

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: state=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic drive(input bit cnt, input bit ld, input logic [2:0] val, input string tag);
    item_t it;
    @(negedge clk);
    count_en = cnt; load_en = ld; load_val = val;
    if (ld) model = val;
    else if (cnt) model = ref_next(model);
    it.exp = model; it.tag = tag;
    sb_q.push_back(it);
  endtask

  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        check(it.tag, state, it.exp);
      end
    end
  end

  initial begin
    #3000000;
    errors++; checks++;
    $display("FAIL watchdog: state=%b expected=done", state);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", state, 3'b000);
    rst_n = 1'b1;

    for (int i = 0; i < 5; i++) drive(1, 0, 3'b000, "R2 cycle");
    for (int s = 0; s < 8; s++) begin
      drive(0, 1, s[2:0], "R6 load");
      drive(1, 0, 3'b000, valid(s[2:0]) ? "R2 step" : "R3 unused step");
    end
    drive(0, 1, 3'b001, "R6 load");
    drive(1, 0, 3'b000, "R4 001 first");
    drive(1, 0, 3'b000, "R4 001 second");
    for (int s = 0; s < 8; s++) begin
      drive(0, 1, s[2:0], "R6 load");
      drive(1, 0, 3'b000, "R4 step1");
      drive(1, 0, 3'b000, "R4 step2");
    end
    drive(0, 0, 3'b111, "R5 hold");
    drive(0, 0, 3'b100, "R5 hold");
    drive(1, 1, 3'b110, "R6 load beats count");
    drive(1, 1, 3'b001, "R6 load beats count");
    drive(0, 0, 3'b000, "R5 hold unused");
    drive(0, 1, 3'b101, "R7 bit order");
    repeat (3) @(negedge clk);
    count_en = 0; load_en = 0;

    checks++;
    if (valid(3'b111) || !valid(3'b101)) begin
      errors++; $display("FAIL R4 bench table: state=%b expected=valid", state);
    end

    count_en = 1;
    @(negedge clk);
    #3 rst_n = 1'b0;
    #2 check("R1 async reset", state, 3'b000);
    @(negedge clk);
    check("R1 reset held", state, 3'b000);
    count_en = 0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule